// File: doc/BRIEF.md
# Tail-Biting Rate-1/3 Convolutional Encoder

This block turns a block of K information bits into three coded streams with a constraint-length-7 convolutional code. It adds no tail bits. The six-stage shift register is seeded with the block's own closing bits, so the trellis ends in the state where it began. Bits arrive one per handshake on a valid/ready input. The block keeps the whole block in local storage and tracks its six most recent bits. When the final bit is accepted it switches to emitting. Each output beat is a 3-bit code word for one input bit, in input order, on a valid/ready output. The final beat carries a last flag.

The block length is a runtime input sampled with the first bit of each block. It is clamped to the range from six to the synthesis bound KMAX. When the final beat has been taken, the block reports whether the register came back to its seeded value, and it is then ready for the next block.

Top module: `tbcc_encoder`

## Requirements
- R1: After synchronous reset, in_ready is 1, and out_valid, out_last and wrap_ok are 0.
- R2: blk_len is sampled when the first bit of a block is accepted. While the block is filling, in_ready stays 1 and exactly K bits are accepted. in_ready is 0 from the cycle after the K-th bit until the final output beat is taken.
- R3: K is blk_len clamped to at least 6 and at most KMAX; a request of 3 yields K=6 and a request above KMAX yields K=KMAX.
- R4: Before the first beat, register stage s_i (i = 0..5) holds input bit c(K-1-i), so s0 is the final bit of the block; after each beat the register shifts, s0 taking the current bit.
- R5: out_code[0] is the modulo-2 sum over the window {c_k, s0, s1, s2, s3, s4, s5}, taken most significant first, masked by octal 133, that is c_k^s1^s2^s4^s5.
- R6: out_code[1] uses octal 171 (c_k^s0^s1^s2^s5) and out_code[2] uses octal 165 (c_k^s0^s1^s3^s5) over the same window.
- R7: Exactly K beats are emitted for k = 0..K-1 in order, and out_last is 1 only on beat K-1.
- R8: While out_valid is 1 and out_ready is 0, out_code and out_last hold their values into the next cycle.
- R9: out_valid rises in the cycle after the K-th input handshake, and in_ready returns in the cycle after the final output handshake.
- R10: In the cycle after the final output handshake, wrap_ok is 1 exactly when the register equals its seeded value. The flag holds until the first bit of the next block is accepted, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_len | input | $clog2(KMAX+1) | Requested block length, sampled with the first bit |
| in_valid | input | 1 | Input bit is valid |
| in_bit | input | 1 | Information bit |
| in_ready | output | 1 | Encoder accepts an input bit |
| out_valid | output | 1 | Code word is valid |
| out_ready | input | 1 | Consumer takes the code word |
| out_code | output | 3 | Coded bits, bit j is stream j |
| out_last | output | 1 | Marks the beat for bit K-1 |
| wrap_ok | output | 1 | Trellis closed on its starting state |

## Verification
Each input bit is registered on the edge where its handshake fires. The first code word is therefore visible one cycle after the K-th handshake, and every later word is visible one cycle after the previous one is taken. wrap_ok and the return of in_ready both follow the final output handshake by one cycle. The bench drives on the falling edge and compares on the next falling edge, so every sample falls half a period after the register that produced it. Stall cycles are inserted on a fixed pattern, and the held word is compared against the value seen on the stalled cycle.

// File: rtl/tbcc_pkg.sv
package tbcc_pkg;

    localparam int unsigned MEM_STAGES = 6;
    localparam int unsigned NSTREAM    = 3;
    localparam int unsigned MIN_LEN    = 6;

    // Generator masks over {c_k, s0, s1, s2, s3, s4, s5}, MSB = current bit
    localparam logic [6:0] POLY_S0 = 7'o133;
    localparam logic [6:0] POLY_S1 = 7'o171;
    localparam logic [6:0] POLY_S2 = 7'o165;

    // bit i holds stage s_i
    typedef logic [MEM_STAGES-1:0] state_t;

    typedef enum logic [0:0] {
        PH_FILL = 1'b0,
        PH_EMIT = 1'b1
    } phase_t;

    typedef struct packed {
        logic               last;
        logic [NSTREAM-1:0] code;
    } beat_t;

    function automatic logic [6:0] poly_of(int unsigned idx);
        case (idx)
            0:       return POLY_S0;
            1:       return POLY_S1;
            default: return POLY_S2;
        endcase
    endfunction

    function automatic logic tap_parity(logic [6:0] poly, logic cur, state_t s);
        logic [6:0] window;
        window = {cur, s[0], s[1], s[2], s[3], s[4], s[5]};
        return ^(poly & window);
    endfunction

    // shift: new s0 = cur, s_i = old s_(i-1)
    function automatic state_t advance(state_t s, logic cur);
        return {s[MEM_STAGES-2:0], cur};
    endfunction

    function automatic int unsigned clamp_len(int unsigned req, int unsigned hi);
        if (req < MIN_LEN) return MIN_LEN;
        if (req > hi)      return hi;
        return req;
    endfunction

endpackage

// File: rtl/tbcc_bitstore.sv
module tbcc_bitstore #(
    parameter  int unsigned KMAX = 64,
    localparam int unsigned IW   = $clog2(KMAX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [IW-1:0] rd_addr,
    output logic          rd_bit
);

    logic [KMAX-1:0] store_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store_q[wr_addr] <= wr_bit;
        end
    end

    assign rd_bit = store_q[rd_addr];

    // R3
    wr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (32'(wr_addr) < KMAX));

endmodule

// File: rtl/tbcc_trellis.sv
module tbcc_trellis
    import tbcc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_en,
    input  logic               cap_bit,
    input  logic               load_en,
    input  logic               step_en,
    input  logic               cur_bit,
    input  logic               close_en,
    input  logic               clear_en,
    output logic [NSTREAM-1:0] code,
    output logic               wrap_ok
);

    state_t tail_q;
    state_t sreg_q;
    state_t seed_q;
    logic   wrap_q;
    state_t sreg_nxt;
    state_t seed_nxt;

    assign sreg_nxt = advance(sreg_q, cur_bit);
    assign seed_nxt = advance(tail_q, cap_bit);

    always_ff @(posedge clk) begin
        if (rst) begin
            tail_q <= '0;
            sreg_q <= '0;
            seed_q <= '0;
            wrap_q <= 1'b0;
        end else begin
            if (cap_en) begin
                tail_q <= seed_nxt;
            end
            if (load_en) begin
                sreg_q <= seed_nxt;
                seed_q <= seed_nxt;
            end else if (step_en) begin
                sreg_q <= sreg_nxt;
            end
            if (close_en) begin
                wrap_q <= (sreg_nxt == seed_q);
            end else if (clear_en) begin
                wrap_q <= 1'b0;
            end
        end
    end

    for (genvar j = 0; j < NSTREAM; j++) begin : g_stream
        assign code[j] = tap_parity(poly_of(j), cur_bit, sreg_q);
    end

    assign wrap_ok = wrap_q;

    // R10
    closure_chk: assert property (@(posedge clk) disable iff (rst)
        close_en |=> wrap_ok);

endmodule

// File: rtl/tbcc_ctrl.sv
module tbcc_ctrl
    import tbcc_pkg::*;
#(
    parameter  int unsigned KMAX = 64,
    localparam int unsigned LW   = $clog2(KMAX + 1),
    localparam int unsigned IW   = $clog2(KMAX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] blk_len,
    input  logic          in_valid,
    output logic          in_ready,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_last,
    output logic [IW-1:0] addr,
    output logic          in_fire,
    output logic          fill_end,
    output logic          out_fire,
    output logic          first_bit
);

    phase_t        phase_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] cnt_q;
    logic [LW-1:0] req_len;
    logic [LW-1:0] eff_len;

    assign req_len   = LW'(clamp_len(32'(blk_len), KMAX));
    assign in_ready  = (phase_q == PH_FILL);
    assign out_valid = (phase_q == PH_EMIT);
    assign in_fire   = in_valid && in_ready;
    assign first_bit = in_fire && (cnt_q == '0);
    assign eff_len   = (cnt_q == '0) ? req_len : len_q;
    assign fill_end  = in_fire && (cnt_q == eff_len - LW'(1));
    assign out_last  = out_valid && (cnt_q == len_q - LW'(1));
    assign out_fire  = out_valid && out_ready;
    assign addr      = cnt_q[IW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FILL;
            len_q   <= LW'(MIN_LEN);
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_FILL: begin
                    if (first_bit) begin
                        len_q <= req_len;
                    end
                    if (fill_end) begin
                        phase_q <= PH_EMIT;
                        cnt_q   <= '0;
                    end else if (in_fire) begin
                        cnt_q <= cnt_q + LW'(1);
                    end
                end
                PH_EMIT: begin
                    if (out_fire) begin
                        if (out_last) begin
                            phase_q <= PH_FILL;
                            cnt_q   <= '0;
                        end else begin
                            cnt_q <= cnt_q + LW'(1);
                        end
                    end
                end
                default: phase_q <= PH_FILL;
            endcase
        end
    end

    // R9
    emit_start_chk: assert property (@(posedge clk) disable iff (rst)
        fill_end |=> (out_valid && !in_ready));

    // R9
    emit_end_chk: assert property (@(posedge clk) disable iff (rst)
        (out_fire && out_last) |=> (in_ready && !out_valid));

    // R7
    beat_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cnt_q < len_q));

    // R3
    len_bound_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (32'(len_q) >= MIN_LEN && 32'(len_q) <= KMAX));

endmodule

// File: rtl/tbcc_encoder.sv
module tbcc_encoder
    import tbcc_pkg::*;
#(
    parameter  int unsigned KMAX = 64,
    localparam int unsigned LW   = $clog2(KMAX + 1),
    localparam int unsigned IW   = $clog2(KMAX)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [LW-1:0] blk_len,
    input  logic          in_valid,
    input  logic          in_bit,
    output logic          in_ready,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [2:0]    out_code,
    output logic          out_last,
    output logic          wrap_ok
);

    logic          in_fire;
    logic          fill_end;
    logic          out_fire;
    logic          first_bit;
    logic          last_raw;
    logic [IW-1:0] addr;
    logic          rd_bit;
    logic [NSTREAM-1:0] code_raw;
    beat_t         beat;

    tbcc_ctrl #(.KMAX(KMAX)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .blk_len   (blk_len),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_last  (last_raw),
        .addr      (addr),
        .in_fire   (in_fire),
        .fill_end  (fill_end),
        .out_fire  (out_fire),
        .first_bit (first_bit)
    );

    tbcc_bitstore #(.KMAX(KMAX)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_fire),
        .wr_addr (addr),
        .wr_bit  (in_bit),
        .rd_addr (addr),
        .rd_bit  (rd_bit)
    );

    tbcc_trellis u_trellis (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (in_fire),
        .cap_bit  (in_bit),
        .load_en  (fill_end),
        .step_en  (out_fire),
        .cur_bit  (rd_bit),
        .close_en (out_fire && last_raw),
        .clear_en (first_bit),
        .code     (code_raw),
        .wrap_ok  (wrap_ok)
    );

    assign beat     = '{last: last_raw, code: code_raw};
    assign out_code = beat.code;
    assign out_last = beat.last;

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_code) && $stable(out_last)));

    // R7
    last_valid_chk: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

endmodule

// File: tb/sim_tbcc_encoder.sv
module sim_tbcc_encoder;

    localparam int unsigned KMAX = 64;
    localparam int unsigned LW   = $clog2(KMAX + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [LW-1:0] blk_len = '0;
    logic          in_valid = 1'b0;
    logic          in_bit = 1'b0;
    logic          in_ready;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [2:0]    out_code;
    logic          out_last;
    logic          wrap_ok;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;
    int bits [KMAX];

    always #2 clk = ~clk;

    tbcc_encoder #(.KMAX(KMAX)) u0 (
        .clk(clk), .rst(rst), .blk_len(blk_len), .in_valid(in_valid), .in_bit(in_bit),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
        .out_code(out_code), .out_last(out_last), .wrap_ok(wrap_ok)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            summary();
        end
    end

    // pattern 0: pseudo-random, 1: all ones, 2: all zeros, 3: alternating
    task automatic run_block(input int req, input int pat, input int unsigned seed, input bit stall);
        int n;
        int s [6];
        int k;
        int t;
        int held_code;
        int held_last;
        bit was_stalled;
        int unsigned x;
        n = (req < 6) ? 6 : ((req > KMAX) ? KMAX : req);
        x = seed;
        for (int i = 0; i < n; i++) begin
            x = x * 32'd1103515245 + 32'd12345;
            case (pat)
                1:       bits[i] = 1;
                2:       bits[i] = 0;
                3:       bits[i] = i % 2;
                default: bits[i] = int'(x[16]);
            endcase
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            // R2: ready throughout the fill
            chk(in_ready == 1'b1, "R2 in_ready during fill", int'(in_ready), 1);
            if (i == 1) begin
                // R10: flag cleared once the new block's first bit is taken
                chk(wrap_ok == 1'b0, "R10 wrap_ok cleared", int'(wrap_ok), 0);
            end
            in_valid = 1'b1;
            in_bit   = bits[i][0];
            blk_len  = LW'(req);
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        // R9, R2, R3: emission starts right after the K-th bit
        chk(out_valid == 1'b1, "R9 out_valid after K bits (R3 length)", int'(out_valid), 1);
        chk(in_ready == 1'b0, "R2 in_ready low while emitting", int'(in_ready), 0);
        // R4: seed s_i = c(K-1-i)
        for (int i = 0; i < 6; i++) s[i] = bits[n - 1 - i];
        k = 0;
        t = 0;
        was_stalled = 0;
        held_code = 0;
        held_last = 0;
        while (k < n) begin
            out_ready = stall ? ((t % 3) != 1) : 1'b1;
            if (was_stalled) begin
                // R8
                chk(out_code == held_code[2:0] && out_last == held_last[0],
                    "R8 hold under stall", {out_last, out_code}, {held_last[0], held_code[2:0]});
            end
            if (out_valid && out_ready) begin
                int c;
                int d0;
                int d1;
                int d2;
                c  = bits[k];
                d0 = c ^ s[1] ^ s[2] ^ s[4] ^ s[5];
                d1 = c ^ s[0] ^ s[1] ^ s[2] ^ s[5];
                d2 = c ^ s[0] ^ s[1] ^ s[3] ^ s[5];
                // R5, R6, R4
                chk(int'(out_code) == (d2 * 4 + d1 * 2 + d0), "R5/R6 code word",
                    int'(out_code), d2 * 4 + d1 * 2 + d0);
                // R7
                chk(out_last == (k == n - 1), "R7 last flag", int'(out_last), int'(k == n - 1));
                for (int i = 5; i > 0; i--) s[i] = s[i - 1];
                s[0] = c;
                k++;
                was_stalled = 0;
            end else begin
                chk(out_valid == 1'b1, "R7 beat missing", int'(out_valid), 1);
                was_stalled = 1;
                held_code = int'(out_code);
                held_last = int'(out_last);
            end
            t++;
            @(posedge clk);
            @(negedge clk);
        end
        out_ready = 1'b0;
        // R9, R7: exactly K beats, then back to fill
        chk(out_valid == 1'b0, "R7 no beat after K", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R9 in_ready after last beat", int'(in_ready), 1);
        // R10
        chk(wrap_ok == 1'b1, "R10 wrap_ok after block", int'(wrap_ok), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        chk(out_last == 1'b0, "R1 out_last", int'(out_last), 0);
        chk(wrap_ok == 1'b0, "R1 wrap_ok", int'(wrap_ok), 0);
        // R3 lower clamp, then upper clamp
        run_block(3, 0, 32'd7, 1'b0);
        run_block(100, 0, 32'd11, 1'b1);
        run_block(6, 1, 32'd1, 1'b0);
        run_block(6, 2, 32'd1, 1'b1);
        run_block(9, 3, 32'd1, 1'b0);
        run_block(KMAX, 3, 32'd1, 1'b1);
        // sweep every legal length
        for (int len = 6; len <= KMAX; len++) begin
            run_block(len, 0, 32'(len * 97 + 5), (len % 2) == 1);
        end
        summary();
    end

endmodule